// File: doc/BRIEF.md
# Conflict-Selective Instruction Cache

This block sits beside the program-memory bus of a Harvard-style core in which that bus carries both instruction fetches and data operands. Each cycle the core presents a fetch address together with a flag saying whether a program-bus data transfer also wants the bus. When both want the bus and the instruction is not already held locally, the block stalls the core for one cycle. During that cycle it fetches the instruction over the bus and keeps a copy. The core then repeats the same request, which now hits, so the instruction comes from the cache and the bus is handed to the data operand.

Fetches that never collide with a data transfer are served straight from memory and are never stored. The small store therefore holds only the instructions of tight loops that actually need it, such as multiply-accumulate kernels and transform butterflies. After their first pass, those loops run one instruction per cycle. Operands on the separate data-memory bus never involve this block.

The store is two-way set associative with one least-recently-used bit per set. A synchronous invalidate clears it in one cycle. The reset input is asynchronous and active low, and its release must be synchronous to `clk`. While `stall_o` is high, the core must hold its fetch address and data request unchanged.

Top module: `conflict_icache`

## Requirements
- R1: While `rst_n` is low and after its release, every entry is invalid: `hit_o` stays 0, and the first conflicting fetch after release stalls.
- R2: A fetch with `pm_data_req_i` low that misses drives `pm_fetch_o`=1, `instr_valid_o`=1 and `instr_o`=`mem_instr_i`, with no stall. It allocates nothing, so a later conflicting fetch of the same address still stalls.
- R3: A fetch with `pm_data_req_i` high that misses raises `stall_o` for that cycle, with `pm_fetch_o`=1, `pm_data_grant_o`=0 and `instr_valid_o`=0. The word on `mem_instr_i` is written into the cache at the next clock edge.
- R4: In the cycle after such a stall, repeating the same request hits. `instr_o` then equals the word captured during the stall, even if memory now returns another value, with `pm_data_grant_o`=1, `pm_fetch_o`=0 and `stall_o`=0.
- R5: A hit with `pm_data_req_i` low delivers the cached word with `pm_fetch_o`=0 and `stall_o`=0.
- R6: With `fetch_valid_i` low, a data request gets `pm_data_grant_o`=1, and `stall_o` and `instr_valid_o` stay 0.
- R7: The set index is the low log2(ENTRIES/2) address bits (bits 3:0 with defaults). Two addresses with the same index can both be resident, and at most one way ever matches.
- R8: An allocation fills the lowest invalid way of the set, or otherwise the least recently used way. Both hits and allocations mark the touched way as most recent.
- R9: Holding `inval_i` high for one cycle makes every entry miss from the next cycle on. An allocation requested in that same cycle is dropped.
- R10: A fetch whose index matches a resident entry but whose upper (tag) bits differ is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_valid_i | input | 1 | An instruction fetch is requested this cycle |
| fetch_addr_i | input | ADDR_W | Fetch address |
| pm_data_req_i | input | 1 | A program-bus data transfer wants the bus this cycle |
| inval_i | input | 1 | Invalidate every entry at this clock edge |
| mem_instr_i | input | INSTR_W | Instruction word returned by program memory for `fetch_addr_i` |
| instr_o | output | INSTR_W | Delivered instruction word (0 when not delivered) |
| instr_valid_o | output | 1 | `instr_o` carries the fetched instruction this cycle |
| hit_o | output | 1 | The fetch was found in the cache |
| stall_o | output | 1 | Conflicting miss: the core must repeat this request next cycle |
| pm_fetch_o | output | 1 | The program bus carries the instruction fetch this cycle |
| pm_data_grant_o | output | 1 | The program bus carries the data transfer this cycle |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 48-bit words and 32 entries in 16 sets. Addresses such as 0x0005, 0x0015 and 0x0025 therefore share set 5 and differ only in their tag. This lets three lines compete for two ways, so LRU eviction order, tag mismatch and same-set coexistence can each be reached with a few fetches. The bench's memory model stamps every word with a changeable salt. A hit can therefore be told apart from a bus fetch by its value alone.

// File: rtl/cicache_pkg.sv
package cicache_pkg;

  localparam int unsigned NUM_WAYS = 2;

  // Per-cycle ownership decision for the program bus slot.
  typedef struct packed {
    logic stall;       // conflicting miss, request repeats next cycle
    logic bus_fetch;   // program bus carries the instruction
    logic data_grant;  // program bus carries the data operand
    logic deliver;     // an instruction word is handed to the core
  } pm_slot_t;

  // Replacement choice: first empty way, else the least recently used one.
  function automatic logic pick_victim(input logic [NUM_WAYS-1:0] way_valid,
                                       input logic                lru_way);
    if (!way_valid[0]) return 1'b0;
    if (!way_valid[1]) return 1'b1;
    return lru_way;
  endfunction

endpackage

// File: rtl/cicache_tag_array.sv
module cicache_tag_array
  import cicache_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inval_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic                wr_en_i,
  input  logic                wr_way_i,
  output logic [NUM_WAYS-1:0] hit_vec_o,
  output logic [NUM_WAYS-1:0] set_valid_o
);

  logic [NUM_WAYS-1:0][SETS-1:0] valid_q;
  logic [NUM_WAYS-1:0][SETS-1:0] valid_d;
  logic [TAG_W-1:0]              tag_q [NUM_WAYS][SETS];

  // Valid bits: invalidate wins over a same-cycle allocation.
  always_comb begin
    valid_d = valid_q;
    if (inval_i) begin
      valid_d = '0;
    end else if (wr_en_i) begin
      valid_d[wr_way_i][idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic tag_we;
    assign tag_we = wr_en_i && !inval_i && (wr_way_i == w[0]);

    always_ff @(posedge clk) begin
      if (tag_we) begin
        tag_q[w][idx_i] <= tag_i;
      end
    end

    assign set_valid_o[w] = valid_q[w][idx_i];
    assign hit_vec_o[w]   = valid_q[w][idx_i] && (tag_q[w][idx_i] == tag_i);
  end

  // R7
  one_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec_o));

  // R9
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inval_i) |-> (hit_vec_o == '0));

  // R3
  single_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) <= $countones($past(valid_q)) + 1);

endmodule

// File: rtl/cicache_data_array.sv
module cicache_data_array
  import cicache_pkg::*;
#(
  parameter int unsigned SETS   = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 48
) (
  input  logic                              clk,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic                              wr_en_i,
  input  logic                              wr_way_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [NUM_WAYS-1:0][DATA_W-1:0]   rdata_o
);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [DATA_W-1:0] store_q [SETS];
    logic              way_we;

    assign way_we = wr_en_i && (wr_way_i == w[0]);

    always_ff @(posedge clk) begin
      if (way_we) begin
        store_q[idx_i] <= wdata_i;
      end
    end

    assign rdata_o[w] = store_q[idx_i];
  end

endmodule

// File: rtl/cicache_lru.sv
module cicache_lru #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             touch_en_i,
  input  logic             touch_way_i,
  output logic             lru_way_o
);

  // Each bit names the way to replace next in its set.
  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (touch_en_i) begin
      lru_d[idx_i] = ~touch_way_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      lru_q <= lru_d;
    end
  end

  assign lru_way_o = lru_q[idx_i];

  // R8
  lru_follows_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(touch_en_i) |-> (lru_q[$past(idx_i)] != $past(touch_way_i)));

endmodule

// File: rtl/conflict_icache.sv
module conflict_icache
  import cicache_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned INSTR_W = 48,
  parameter int unsigned ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  input  logic               pm_data_req_i,
  input  logic               inval_i,
  input  logic [INSTR_W-1:0] mem_instr_i,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_valid_o,
  output logic               hit_o,
  output logic               stall_o,
  output logic               pm_fetch_o,
  output logic               pm_data_grant_o
);

  localparam int unsigned SETS  = ENTRIES / NUM_WAYS;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]                  set_idx;
  logic [TAG_W-1:0]                  addr_tag;
  logic [NUM_WAYS-1:0]               hit_vec;
  logic [NUM_WAYS-1:0]               set_valid;
  logic [NUM_WAYS-1:0][INSTR_W-1:0]  way_words;
  logic                              lookup_hit;
  logic                              hit_way;
  logic                              lru_way;
  logic                              victim_way;
  logic                              alloc_en;
  logic                              touch_en;
  logic                              touch_way;
  pm_slot_t                          slot;

  assign set_idx  = fetch_addr_i[IDX_W-1:0];
  assign addr_tag = fetch_addr_i[ADDR_W-1:IDX_W];

  cicache_tag_array #(
    .SETS (SETS),
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) tags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .inval_i    (inval_i),
    .idx_i      (set_idx),
    .tag_i      (addr_tag),
    .wr_en_i    (alloc_en),
    .wr_way_i   (victim_way),
    .hit_vec_o  (hit_vec),
    .set_valid_o(set_valid)
  );

  cicache_data_array #(
    .SETS  (SETS),
    .IDX_W (IDX_W),
    .DATA_W(INSTR_W)
  ) words_i (
    .clk     (clk),
    .idx_i   (set_idx),
    .wr_en_i (alloc_en),
    .wr_way_i(victim_way),
    .wdata_i (mem_instr_i),
    .rdata_o (way_words)
  );

  cicache_lru #(
    .SETS (SETS),
    .IDX_W(IDX_W)
  ) lru_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_i      (set_idx),
    .touch_en_i (touch_en),
    .touch_way_i(touch_way),
    .lru_way_o  (lru_way)
  );

  assign lookup_hit = |hit_vec;
  assign hit_way    = hit_vec[1];
  assign victim_way = pick_victim(set_valid, lru_way);

  // Program-bus slot arbitration for this cycle.
  always_comb begin
    slot = '0;
    if (fetch_valid_i) begin
      if (lookup_hit) begin
        slot.deliver    = 1'b1;
        slot.data_grant = pm_data_req_i;
      end else if (pm_data_req_i) begin
        slot.stall      = 1'b1;
        slot.bus_fetch  = 1'b1;
      end else begin
        slot.bus_fetch  = 1'b1;
        slot.deliver    = 1'b1;
      end
    end else begin
      slot.data_grant = pm_data_req_i;
    end
  end

  assign alloc_en  = slot.stall && !inval_i;
  assign touch_en  = (fetch_valid_i && lookup_hit) || alloc_en;
  assign touch_way = lookup_hit ? hit_way : victim_way;

  always_comb begin
    instr_o = '0;
    if (slot.deliver) begin
      instr_o = lookup_hit ? way_words[hit_way] : mem_instr_i;
    end
  end

  assign instr_valid_o   = slot.deliver;
  assign hit_o           = fetch_valid_i && lookup_hit;
  assign stall_o         = slot.stall;
  assign pm_fetch_o      = slot.bus_fetch;
  assign pm_data_grant_o = slot.data_grant;

  // R3
  stall_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (pm_fetch_o && !pm_data_grant_o && !instr_valid_o));

  // R4
  retry_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stall_o) && !$past(inval_i) && fetch_valid_i &&
     (fetch_addr_i == $past(fetch_addr_i))) |-> (hit_o && !stall_o));

  // R5
  hit_frees_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> !pm_fetch_o);

  // R6
  idle_grants_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid_i && pm_data_req_i) |-> (pm_data_grant_o && !stall_o));

endmodule

// File: tb/conflict_icache_tb.sv
module conflict_icache_tb_top;

  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned INSTR_W = 48;

  logic               clk;
  logic               rst_n;
  logic               fetch_valid;
  logic [ADDR_W-1:0]  fetch_addr;
  logic               pm_data_req;
  logic               inval;
  logic [15:0]        salt;
  logic [INSTR_W-1:0] mem_instr;
  logic [INSTR_W-1:0] instr;
  logic               instr_valid;
  logic               hit;
  logic               stall;
  logic               pm_fetch;
  logic               pm_data_grant;

  int checks;
  int failures;

  conflict_icache #(
    .ADDR_W (ADDR_W),
    .INSTR_W(INSTR_W),
    .ENTRIES(32)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid_i  (fetch_valid),
    .fetch_addr_i   (fetch_addr),
    .pm_data_req_i  (pm_data_req),
    .inval_i        (inval),
    .mem_instr_i    (mem_instr),
    .instr_o        (instr),
    .instr_valid_o  (instr_valid),
    .hit_o          (hit),
    .stall_o        (stall),
    .pm_fetch_o     (pm_fetch),
    .pm_data_grant_o(pm_data_grant)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Memory model: word stamped with the current salt.
  function automatic logic [INSTR_W-1:0] word_of(input logic [15:0] a, input logic [15:0] s);
    return {s, a, ~a};
  endfunction

  assign mem_instr = word_of(fetch_addr, salt);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic fv, input logic [15:0] a, input logic dr, input logic iv);
    fetch_valid = fv;
    fetch_addr  = a;
    pm_data_req = dr;
    inval       = iv;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    drive(1'b1, 16'h0040, 1'b1, 1'b0);
    chk("R1 hit in reset", hit, 0);
    chk("R1 stall in reset", stall, 1);
    rst_n = 1'b1;
    #1;
    chk("R1 hit after release", hit, 0);
    chk("R1 first conflict stalls", stall, 1);
    step();
  endtask

  task automatic t_plain_miss();
    drive(1'b1, 16'h0100, 1'b0, 1'b0);
    chk("R2 hit", hit, 0);
    chk("R2 stall", stall, 0);
    chk("R2 bus fetch", pm_fetch, 1);
    chk("R2 valid", instr_valid, 1);
    chk("R2 word", instr, word_of(16'h0100, salt));
    step();
    drive(1'b1, 16'h0100, 1'b1, 1'b0);
    chk("R2 not allocated", stall, 1);
    step();
    drive(1'b1, 16'h0100, 1'b1, 1'b0);
    chk("R4 retry hits", hit, 1);
    step();
  endtask

  task automatic t_conflict();
    logic [INSTR_W-1:0] cached;
    salt = 16'hA1A1;
    drive(1'b1, 16'h0203, 1'b1, 1'b0);
    cached = word_of(16'h0203, salt);
    chk("R3 stall", stall, 1);
    chk("R3 bus fetch", pm_fetch, 1);
    chk("R3 no grant", pm_data_grant, 0);
    chk("R3 no deliver", instr_valid, 0);
    step();
    salt = 16'h5E5E;
    drive(1'b1, 16'h0203, 1'b1, 1'b0);
    chk("R4 hit", hit, 1);
    chk("R4 cached word", instr, cached);
    chk("R4 grant", pm_data_grant, 1);
    chk("R4 bus free", pm_fetch, 0);
    chk("R4 no stall", stall, 0);
    step();
    drive(1'b1, 16'h0203, 1'b0, 1'b0);
    chk("R5 hit", hit, 1);
    chk("R5 bus free", pm_fetch, 0);
    chk("R5 word", instr, cached);
    chk("R5 no stall", stall, 0);
    step();
  endtask

  task automatic t_no_fetch();
    drive(1'b0, 16'h0000, 1'b1, 1'b0);
    chk("R6 grant", pm_data_grant, 1);
    chk("R6 stall", stall, 0);
    chk("R6 valid", instr_valid, 0);
    step();
  endtask

  task automatic t_ways();
    drive(1'b1, 16'h0005, 1'b1, 1'b0);
    chk("R7 A stall", stall, 1);
    step();
    drive(1'b1, 16'h0015, 1'b1, 1'b0);
    chk("R7 B stall", stall, 1);
    step();
    drive(1'b1, 16'h0005, 1'b0, 1'b0);
    chk("R7 A resident", hit, 1);
    step();
    drive(1'b1, 16'h0015, 1'b0, 1'b0);
    chk("R7 B resident", hit, 1);
    step();
    drive(1'b1, 16'h0025, 1'b0, 1'b0);
    chk("R10 tag mismatch miss", hit, 0);
    chk("R10 tag mismatch fetch", pm_fetch, 1);
    step();
  endtask

  task automatic t_lru();
    drive(1'b1, 16'h0015, 1'b0, 1'b0);
    chk("R8 touch B", hit, 1);
    step();
    drive(1'b1, 16'h0005, 1'b0, 1'b0);
    chk("R8 touch A", hit, 1);
    step();
    drive(1'b1, 16'h0025, 1'b1, 1'b0);
    chk("R8 C stall", stall, 1);
    step();
    drive(1'b1, 16'h0025, 1'b0, 1'b0);
    chk("R8 C resident", hit, 1);
    step();
    drive(1'b1, 16'h0005, 1'b0, 1'b0);
    chk("R8 A kept", hit, 1);
    step();
    drive(1'b1, 16'h0015, 1'b0, 1'b0);
    chk("R8 B evicted", hit, 0);
    step();
  endtask

  task automatic t_inval();
    drive(1'b0, 16'h0000, 1'b0, 1'b1);
    step();
    drive(1'b1, 16'h0005, 1'b0, 1'b0);
    chk("R9 A gone", hit, 0);
    step();
    drive(1'b1, 16'h0203, 1'b0, 1'b0);
    chk("R9 other set gone", hit, 0);
    step();
    drive(1'b1, 16'h0300, 1'b1, 1'b1);
    chk("R9 stall with inval", stall, 1);
    step();
    drive(1'b1, 16'h0300, 1'b1, 1'b0);
    chk("R9 alloc dropped", stall, 1);
    step();
    drive(1'b1, 16'h0300, 1'b1, 1'b0);
    chk("R9 later alloc hits", hit, 1);
    step();
  endtask

  initial begin
    checks      = 0;
    failures    = 0;
    rst_n       = 1'b0;
    salt        = 16'h1234;
    fetch_valid = 1'b0;
    fetch_addr  = '0;
    pm_data_req = 1'b0;
    inval       = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_plain_miss();
    t_conflict();
    t_no_fetch();
    t_ways();
    t_lru();
    t_inval();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule